// File: doc/BRIEF.md
# Pipelined Lane-Partitioned Multi-Operand Adder

This block adds up a parameterised number of 16-bit operand words into a single 16-bit result. Two run-time controls can cut the word into narrower lanes, and no carry ever crosses an active cut. The block suits packed-lane arithmetic, where one datapath must add four-, eight- or sixteen-bit quantities depending on the instruction in flight.

The operands are reduced by a binary tree of lane-aware two-input adders. Level 0 of the tree is the operand input. Level k is the output of the k-th adder layer. A bit mask parameter picks the levels that carry a pipeline register. The two lane controls pass through the same registers as the data, so every result is cut the way its operands were cut. With an empty mask the block is purely combinational.

Top module: `part_sum_tree`

## Requirements
- R1: Operand word i occupies bits [16*i+15:16*i] of `operands_i`. With both controls low, `sum_o` is the sum of all N_IN words modulo 2^16.
- R2: With only `split_hi` high (cut at bit 8), bits [15:8] and [7:0] of the result are independent sums of the matching operand bits.
- R3: With only `split_lo` high (cut at bit 4), bits [15:4] and [3:0] of the result are independent sums.
- R4: With both controls high, the lanes [15:8], [7:4] and [3:0] are summed independently.
- R5: A lane's carry out of its top bit is dropped, so each lane wraps at its own width.
- R6: With N_IN = 0 the result is always 0.
- R7: With DEPTH = the number of adder levels needed for N_IN words, latency in clock cycles equals the number of set bits of REG_LEVELS at positions 0..DEPTH. Set bits above DEPTH have no effect.
- R8: With REG_LEVELS = 0 the result follows the inputs in the same cycle.
- R9: A result is always cut by the control values applied together with its operands, even when the controls change every cycle.
- R10: While `rst_n` is low, every pipeline register reads 0, so a registered build outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_lo | input | 1 | Cut the word between bits 3 and 4 |
| split_hi | input | 1 | Cut the word between bits 7 and 8 |
| operands_i | input | max(N_IN,1)*16 | Packed operand words, word 0 lowest |
| sum_o | output | 16 | Lane-wise sum of all operands |

## Verification
The bench builds four copies side by side. The first has six operands with registers at levels 0 and 2, giving two cycles. The second has no operands at all. The third has five operands and no registers. The fourth has fifteen operands with mask bits 0, 1, 3 and 7; bit 7 lies beyond the four-level tree, so latency is three. Together these reach the empty-input case, a purely combinational path, odd operand counts that pass a word through unpaired, and an ignored mask bit. A new vector every cycle, with the controls changing at random, exposes any control that falls out of step with its data.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int WORD_W = 16;
    localparam int CUT_LO = 4;
    localparam int CUT_HI = 8;

    function automatic int reduce_count(int n, int lvl);
        int c;
        c = n;
        for (int k = 0; k < lvl; k++) c = (c + 1) / 2;
        return c;
    endfunction

    function automatic int stage_out(int cnt, int add);
        return (add != 0) ? (cnt + 1) / 2 : cnt;
    endfunction

    function automatic int tree_depth(int n);
        int c;
        int d;
        c = (n < 1) ? 1 : n;
        d = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            d++;
        end
        return d;
    endfunction

    function automatic int kept_levels(logic [31:0] mask, int depth);
        int cnt;
        cnt = 0;
        for (int k = 0; k < 32; k++)
            if (k <= depth && mask[k]) cnt++;
        return cnt;
    endfunction
endpackage

// File: rtl/pst_lane_adder.sv
module pst_lane_adder
    import pst_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              split_lo_i,
    input  logic              split_hi_i,
    output logic [WORD_W-1:0] sum_o
);
    localparam int W0 = CUT_LO;
    localparam int W1 = CUT_HI - CUT_LO;
    localparam int W2 = WORD_W - CUT_HI;

    logic [W0:0]   seg0;
    logic [W1:0]   seg1;
    logic [W2-1:0] seg2;
    logic          carry0;
    logic          carry1;

    always_comb begin
        seg0   = {1'b0, a_i[CUT_LO-1:0]} + {1'b0, b_i[CUT_LO-1:0]};
        carry0 = seg0[W0] & ~split_lo_i;
        seg1   = {1'b0, a_i[CUT_HI-1:CUT_LO]} + {1'b0, b_i[CUT_HI-1:CUT_LO]}
               + {{W1{1'b0}}, carry0};
        carry1 = seg1[W1] & ~split_hi_i;
        seg2   = a_i[WORD_W-1:CUT_HI] + b_i[WORD_W-1:CUT_HI] + {{(W2-1){1'b0}}, carry1};
        sum_o  = {seg2, seg1[W1-1:0], seg0[W0-1:0]};
    end
endmodule

// File: rtl/pst_stage.sv
module pst_stage
    import pst_pkg::*;
#(
    parameter int CNT_IN = 2,
    parameter int DO_ADD = 1,
    parameter int KEEP   = 1
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [CNT_IN*WORD_W-1:0]                     words_i,
    input  logic                                         split_lo_i,
    input  logic                                         split_hi_i,
    output logic [stage_out(CNT_IN, DO_ADD)*WORD_W-1:0]  words_o,
    output logic                                         split_lo_o,
    output logic                                         split_hi_o
);
    localparam int CNT_OUT = stage_out(CNT_IN, DO_ADD);
    localparam int LW0     = CUT_LO;
    localparam int LW1     = CUT_HI - CUT_LO;
    localparam int LW2     = WORD_W - CUT_HI;
    localparam int LWU     = WORD_W - CUT_LO;

    typedef struct packed {
        logic [CNT_OUT-1:0][WORD_W-1:0] words;
        logic                           split_lo;
        logic                           split_hi;
    } stage_t;

    logic [CNT_OUT-1:0][WORD_W-1:0] pair_sum;
    stage_t                         st_d;

    for (genvar j = 0; j < CNT_OUT; j++) begin : g_pair
        if (DO_ADD != 0 && (2 * j + 1) < CNT_IN) begin : g_add
            logic [WORD_W-1:0] op_a;
            logic [WORD_W-1:0] op_b;
            assign op_a = words_i[(2*j)*WORD_W +: WORD_W];
            assign op_b = words_i[(2*j+1)*WORD_W +: WORD_W];

            pst_lane_adder u_add (
                .a_i       (op_a),
                .b_i       (op_b),
                .split_lo_i(split_lo_i),
                .split_hi_i(split_hi_i),
                .sum_o     (pair_sum[j])
            );

            AST_HIGH_LANE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
                split_hi_i |-> pair_sum[j][WORD_W-1:CUT_HI] ==
                    LW2'(op_a[WORD_W-1:CUT_HI] + op_b[WORD_W-1:CUT_HI])); // R2
            AST_UPPER_LANE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
                (split_lo_i && !split_hi_i) |-> pair_sum[j][WORD_W-1:CUT_LO] ==
                    LWU'(op_a[WORD_W-1:CUT_LO] + op_b[WORD_W-1:CUT_LO])); // R3
            AST_MID_LANE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
                (split_lo_i && split_hi_i) |-> pair_sum[j][CUT_HI-1:CUT_LO] ==
                    LW1'(op_a[CUT_HI-1:CUT_LO] + op_b[CUT_HI-1:CUT_LO])); // R4
            AST_LOW_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |-> pair_sum[j][CUT_LO-1:0] ==
                    LW0'(op_a[CUT_LO-1:0] + op_b[CUT_LO-1:0])); // R5
        end else begin : g_pass
            localparam int SRC = (DO_ADD != 0) ? 2 * j : j;
            assign pair_sum[j] = words_i[SRC*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        st_d.words    = pair_sum;
        st_d.split_lo = split_lo_i;
        st_d.split_hi = split_hi_i;
    end

    if (KEEP != 0) begin : g_reg
        stage_t st_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign words_o    = st_q.words;
        assign split_lo_o = st_q.split_lo;
        assign split_hi_o = st_q.split_hi;

        AST_SPLIT_TRAVELS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> {split_lo_o, split_hi_o} == $past({split_lo_i, split_hi_i})); // R9
        AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |-> (words_o == '0)); // R10
    end else begin : g_comb
        assign words_o    = st_d.words;
        assign split_lo_o = st_d.split_lo;
        assign split_hi_o = st_d.split_hi;
    end
endmodule

// File: rtl/part_sum_tree.sv
module part_sum_tree
    import pst_pkg::*;
#(
    parameter int          N_IN       = 6,
    parameter logic [31:0] REG_LEVELS = 32'h0000_0005
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      split_lo,
    input  logic                                      split_hi,
    input  logic [((N_IN > 0) ? N_IN : 1)*WORD_W-1:0] operands_i,
    output logic [WORD_W-1:0]                         sum_o
);
    localparam int NP      = (N_IN > 0) ? N_IN : 1;
    localparam int DEPTH   = tree_depth(NP);
    localparam int LATENCY = kept_levels(REG_LEVELS, DEPTH);
    localparam int IN_W    = NP * WORD_W + 2;
    localparam int CAP     = LATENCY + 2;

    for (genvar s = 0; s <= DEPTH; s++) begin : g_lvl
        localparam int CIN  = reduce_count(NP, (s > 0) ? s - 1 : 0);
        localparam int COUT = stage_out(CIN, (s > 0) ? 1 : 0);

        logic [CIN*WORD_W-1:0]  w_in;
        logic                   lo_in;
        logic                   hi_in;
        logic [COUT*WORD_W-1:0] w_out;
        logic                   lo_out;
        logic                   hi_out;

        if (s == 0) begin : g_src
            assign w_in  = operands_i;
            assign lo_in = split_lo;
            assign hi_in = split_hi;
        end else begin : g_chain
            assign w_in  = g_lvl[s-1].w_out;
            assign lo_in = g_lvl[s-1].lo_out;
            assign hi_in = g_lvl[s-1].hi_out;
        end

        if (s == 0 && !REG_LEVELS[0]) begin : g_wire
            assign w_out  = w_in;
            assign lo_out = lo_in;
            assign hi_out = hi_in;
        end else begin : g_stage
            pst_stage #(
                .CNT_IN(CIN),
                .DO_ADD((s > 0) ? 1 : 0),
                .KEEP  (REG_LEVELS[s] ? 1 : 0)
            ) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .words_i   (w_in),
                .split_lo_i(lo_in),
                .split_hi_i(hi_in),
                .words_o   (w_out),
                .split_lo_o(lo_out),
                .split_hi_o(hi_out)
            );
        end
    end

    logic [WORD_W-1:0] tree_sum;
    logic              tail_lo;
    logic              tail_hi;
    assign tree_sum = g_lvl[DEPTH].w_out[WORD_W-1:0];
    assign tail_lo  = g_lvl[DEPTH].lo_out;
    assign tail_hi  = g_lvl[DEPTH].hi_out;
    assign sum_o    = (N_IN == 0) ? '0 : tree_sum;

    typedef struct packed {
        logic [IN_W-1:0] last_in;
        logic [7:0]      quiet;
    } mon_t;

    mon_t            mon_d;
    mon_t            mon_q;
    logic [IN_W-1:0] in_now;

    always_comb begin
        in_now        = {operands_i, split_lo, split_hi};
        mon_d.last_in = in_now;
        if (in_now != mon_q.last_in)   mon_d.quiet = '0;
        else if (mon_q.quiet >= CAP)   mon_d.quiet = mon_q.quiet;
        else                           mon_d.quiet = mon_q.quiet + 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q.quiet >= CAP && in_now == mon_q.last_in) |=>
            ($stable(sum_o) && $stable({tail_lo, tail_hi}))); // R7
endmodule

// File: tb/sim_part_sum_tree.sv
module sim_part_sum_tree;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic         split_lo;
    logic         split_hi;
    logic [15:0]  w [15];
    logic [239:0] bus;
    logic [15:0]  s0, s1, s2, s3;

    always_comb begin
        for (int i = 0; i < 15; i++) bus[i*16 +: 16] = w[i];
    end

    part_sum_tree #(.N_IN(6),  .REG_LEVELS(32'h05)) u0 (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .operands_i(bus[6*16-1:0]), .sum_o(s0));
    part_sum_tree #(.N_IN(0),  .REG_LEVELS(32'h01)) u1 (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .operands_i(bus[15:0]), .sum_o(s1));
    part_sum_tree #(.N_IN(5),  .REG_LEVELS(32'h00)) u2 (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .operands_i(bus[5*16-1:0]), .sum_o(s2));
    part_sum_tree #(.N_IN(15), .REG_LEVELS(32'h8B)) u3 (
        .clk(clk), .rst_n(rst_n), .split_lo(split_lo), .split_hi(split_hi),
        .operands_i(bus), .sum_o(s3));

    typedef struct {
        logic [15:0] w [15];
        bit          lo;
        bit          hi;
    } vec_t;

    vec_t hist [4];
    int   checks = 0;
    int   errors = 0;

    function automatic logic [15:0] ref_sum(vec_t v, int n);
        logic [15:0] m [3];
        logic [15:0] y;
        logic [15:0] acc;
        int          nm;
        if (v.lo && v.hi) begin
            m[0] = 16'hFF00; m[1] = 16'h00F0; m[2] = 16'h000F; nm = 3;
        end else if (v.hi) begin
            m[0] = 16'hFF00; m[1] = 16'h00FF; m[2] = 16'h0000; nm = 2;
        end else if (v.lo) begin
            m[0] = 16'hFFF0; m[1] = 16'h000F; m[2] = 16'h0000; nm = 2;
        end else begin
            m[0] = 16'hFFFF; m[1] = 16'h0000; m[2] = 16'h0000; nm = 1;
        end
        y = '0;
        for (int k = 0; k < nm; k++) begin
            acc = '0;
            for (int i = 0; i < n; i++) acc = acc + (v.w[i] & m[k]);
            y = y | (acc & m[k]);
        end
        return y;
    endfunction

    function automatic string mode_tag(vec_t v);
        if (v.lo && v.hi) return "R4";
        if (v.hi)         return "R2";
        if (v.lo)         return "R3";
        return "R1";
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(vec_t v);
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = v;
        for (int i = 0; i < 15; i++) w[i] = v.w[i];
        split_lo = v.lo;
        split_hi = v.hi;
    endtask

    task automatic check_all();
        string t0;
        bit    ones;
        ones = 1'b1;
        for (int i = 0; i < 6; i++) if (hist[2].w[i] != 16'hFFFF) ones = 1'b0;
        if (hist[0].lo != hist[2].lo || hist[0].hi != hist[2].hi) t0 = "R9";
        else if (ones)                                            t0 = "R5";
        else                                                      t0 = mode_tag(hist[2]);
        check(t0,   s0, ref_sum(hist[2], 6));
        check("R6", s1, 16'h0000);
        check("R8", s2, ref_sum(hist[0], 5));
        check("R7", s3, ref_sum(hist[3], 15));
    endtask

    initial begin
        vec_t v;
        void'($urandom(32'd7341));
        rst_n = 1'b0;
        for (int i = 0; i < 15; i++) w[i] = 16'($urandom);
        split_lo = 1'b1;
        split_hi = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R10", s0, 16'h0000);
        check("R10", s3, 16'h0000);
        check("R6",  s1, 16'h0000);

        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 15; k++) hist[i].w[k] = '0;
            hist[i].lo = 1'b0;
            hist[i].hi = 1'b0;
        end

        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 600; c++) begin
            if (c < 16) begin
                for (int i = 0; i < 15; i++) begin
                    case (c / 4)
                        0:       v.w[i] = 16'hFFFF;
                        1:       v.w[i] = 16'h8888;
                        2:       v.w[i] = 16'h1111 * 16'(i + 1);
                        default: v.w[i] = 16'h0F0F;
                    endcase
                end
                v.lo = c[0];
                v.hi = c[1];
            end else begin
                for (int i = 0; i < 15; i++) v.w[i] = 16'($urandom);
                v.lo = 1'($urandom);
                v.hi = 1'($urandom);
            end
            apply(v);
            #1;
            check_all();
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule